// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block connects a 16-bit register-style host bus to a raw 8-bit NAND flash device. Software sees five byte-wide locations: a data port, a mode register, a status register, a ready-request flag register and an interrupt mask. The bits of the mode register drive the device's chip-enable, command-latch, address-latch and write-protect pins with no decoding. Software therefore puts the device in command, address or data phase by writing a mode value. It then moves bytes through the data port.

Host requests arrive on a valid/ready channel. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the acceptance of a data-port access until all of its NAND byte cycles have completed, so the host is back-pressured for the duration of the strobes. Every accepted request produces exactly one `rsp_valid` pulse, carrying read data. The response channel has no back-pressure, and the host must take a response in the cycle it is presented. A wide data access becomes two NAND byte cycles with the low byte first. A narrow data access becomes one byte cycle, which is how command and address bytes are issued.

The device's ready/busy line is synchronized and shown as a busy bit in the status register. A low-to-high transition of that line sets a sticky ready-request flag. The flag drives `irq` when the mask enables it.

Top module: `nbb_top`

## Requirements
- R1: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe`, `irq` and `rsp_valid` are 0, `req_ready` is 1, and the mode (offset 4), mask (offset 7) and flag (offset 6) registers read 0.
- R2: Mode bits drive the pins: bit 4 set gives `nand_ce_n`=0, bit 0 drives `nand_cle`, bit 1 drives `nand_ale`, bit 7 drives `nand_wp_n`. Mode 0x95 is command phase, 0x96 is address phase, 0x94 is data phase and 0x00 is standby with chip enable released. The full byte reads back.
- R3: A wide (`req_wide`=1) write to offset 0 produces two `nand_we_n` pulses carrying `req_wdata[7:0]` first and then `req_wdata[15:8]`, with `nand_dq_oe` high at each rising strobe edge.
- R4: A narrow write to offset 0 produces one `nand_we_n` pulse carrying `req_wdata[7:0]` under the current pin phase (for example CLE high in mode 0x95).
- R5: A wide read of offset 0 produces two `nand_re_n` pulses. The first byte returns in `rsp_rdata[7:0]` and the second in `rsp_rdata[15:8]`. A narrow read produces one pulse, with the byte in bits [7:0] and zero in bits [15:8].
- R6: Each strobe stays low for exactly PULSE_CYC clocks. `nand_we_n` and `nand_re_n` are never low together.
- R7: A data access with N byte cycles raises `rsp_valid` N*(PULSE_CYC+RECOV_CYC)+1 cycles after the accepting edge, and `req_ready` is low in between. A register access responds on the cycle after acceptance. The mode register does not change while `req_ready` is low.
- R8: Status (offset 5) bit 7 reads 1 while `nand_rb` is low (busy) and 0 once it is high. Bits 6:0 read 0.
- R9: A rising edge of `nand_rb` sets flag bit 0 at offset 6. A falling edge does not set it. Writing 0x0F to offset 6 clears it.
- R10: `irq` is high only while the flag is set and mask bits 7 and 0 are both 1. Mask 0x81 enables the interrupt, while 0x00 or 0x01 keep it low and leave the flag pending.
- R11: Offsets other than 0 and 4 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data with the response |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Device ready (1) / busy (0), asynchronous |
| irq | output | 1 | Ready-request interrupt |

## Verification
The bench targets byte order in both directions. A design that swapped halves would return 0x1234 where 0x3412 is expected, or put the high byte on the bus first. It also measures the strobe width and the accept-to-response latency in clock counts, which catches an off-by-one in the phase counters. It checks that a narrow read leaves the high half zero rather than holding stale data. On the interrupt side, the bench drives a falling ready/busy edge, which must not set the flag. It uses a mask that enables only one of the two required bits. It also clears the flag while the interrupt is enabled, to expose a flag that ignores the clear or an `irq` gated by a single mask bit.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_FLAG   = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 3'd7;

  localparam int MODE_CLE_BIT = 0;
  localparam int MODE_ALE_BIT = 1;
  localparam int MODE_CE_BIT  = 4;
  localparam int MODE_WP_BIT  = 7;

  localparam int STATUS_BUSY_BIT = 7;
  localparam int MASK_GLOBAL_BIT = 7;
  localparam int MASK_READY_BIT  = 0;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } phase_t;
endpackage

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_level,
  output logic rb_rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= rb_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b1;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rb_level = chain_q[STAGES-1];
  assign rb_rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
  import nbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rb_level,
  input  logic              rb_rise,
  output logic [7:0]        mode_q,
  output logic [7:0]        mask_q,
  output logic              flag_q,
  output logic [7:0]        rd_val,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == OFF_MODE) mode_q <= wdata;
      if (addr == OFF_MASK) mask_q <= wdata;
    end
  end

  // sticky ready-request flag: a new edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    flag_q <= 1'b0;
    else if (rb_rise)                              flag_q <= 1'b1;
    else if (wr_en && addr == OFF_FLAG && wdata[0]) flag_q <= 1'b0;
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      OFF_MODE:   rd_val = mode_q;
      OFF_STATUS: rd_val[STATUS_BUSY_BIT] = ~rb_level;
      OFF_FLAG:   rd_val[0] = flag_q;
      OFF_MASK:   rd_val = mask_q;
      default:    rd_val = '0;
    endcase
  end

  assign irq = flag_q & mask_q[MASK_GLOBAL_BIT] & mask_q[MASK_READY_BIT];
endmodule

// File: rtl/nbb_strobe.sv
module nbb_strobe
  import nbb_pkg::*;
#(
  parameter int PULSE_CYC = 3,
  parameter int RECOV_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_read,
  input  logic        two_bytes,
  input  logic [15:0] wdata,
  input  logic [7:0]  dq_i,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dq_o,
  output logic        dq_oe,
  output logic [15:0] rdata,
  output logic        idle,
  output logic        fin
);
  localparam int MAXC  = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(RECOV_CYC - 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idx_q;
  logic             rd_q;
  logic             two_q;
  logic [15:0]      wd_q;
  logic [15:0]      buf_q;
  logic             low_end;
  logic             high_end;

  assign low_end  = (ph_q == PH_LOW)  && (cnt_q == LOW_LAST);
  assign high_end = (ph_q == PH_HIGH) && (cnt_q == HIGH_LAST);
  assign fin      = high_end && (idx_q || !two_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= 1'b0;
      rd_q  <= 1'b0;
      two_q <= 1'b0;
      wd_q  <= '0;
      buf_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
            idx_q <= 1'b0;
            rd_q  <= is_read;
            two_q <= two_bytes;
            wd_q  <= wdata;
            buf_q <= '0;
          end
        end
        PH_LOW: begin
          if (low_end) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
            // sample at the strobe's rising edge
            if (rd_q) begin
              if (idx_q) buf_q[15:8] <= dq_i;
              else       buf_q[7:0]  <= dq_i;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (high_end) begin
            cnt_q <= '0;
            if (fin) begin
              ph_q <= PH_IDLE;
            end else begin
              ph_q  <= PH_LOW;
              idx_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign we_n  = !((ph_q == PH_LOW) && !rd_q);
  assign re_n  = !((ph_q == PH_LOW) &&  rd_q);
  assign dq_oe = (ph_q != PH_IDLE) && !rd_q;
  assign dq_o  = idx_q ? wd_q[15:8] : wd_q[7:0];
  assign rdata = buf_q;
  assign idle  = (ph_q == PH_IDLE);
endmodule

// File: rtl/nbb_top.sv
module nbb_top
  import nbb_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int RECOV_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_wp_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb,
  output logic              irq
);
  logic        hs;
  logic        is_data;
  logic        eng_start;
  logic        reg_wr;
  logic        eng_idle;
  logic        eng_fin;
  logic [15:0] eng_rdata;
  logic        rb_level;
  logic        rb_rise;
  logic [7:0]  mode_q;
  logic [7:0]  mask_q;
  logic        flag_q;
  logic [7:0]  reg_rd;
  logic        rsp_valid_q;
  logic [15:0] rsp_rdata_q;

  assign req_ready = eng_idle;
  assign hs        = req_valid & req_ready;
  assign is_data   = (req_addr == OFF_DATA);
  assign eng_start = hs & is_data;
  assign reg_wr    = hs & req_write & ~is_data;

  nbb_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nand_rb),
    .rb_level (rb_level),
    .rb_rise  (rb_rise)
  );

  nbb_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (req_addr),
    .wdata    (req_wdata[7:0]),
    .rb_level (rb_level),
    .rb_rise  (rb_rise),
    .mode_q   (mode_q),
    .mask_q   (mask_q),
    .flag_q   (flag_q),
    .rd_val   (reg_rd),
    .irq      (irq)
  );

  nbb_strobe #(.PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .is_read   (~req_write),
    .two_bytes (req_wide),
    .wdata     (req_wdata),
    .dq_i      (nand_dq_i),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .dq_o      (nand_dq_o),
    .dq_oe     (nand_dq_oe),
    .rdata     (eng_rdata),
    .idle      (eng_idle),
    .fin       (eng_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= (hs & ~is_data) | eng_fin;
      if (hs && !is_data)
        rsp_rdata_q <= req_write ? 16'h0000 : {8'h00, reg_rd};
      else if (eng_fin)
        rsp_rdata_q <= eng_rdata;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  assign nand_ce_n = ~mode_q[MODE_CE_BIT];
  assign nand_cle  =  mode_q[MODE_CLE_BIT];
  assign nand_ale  =  mode_q[MODE_ALE_BIT];
  assign nand_wp_n =  mode_q[MODE_WP_BIT];
endmodule

// File: rtl/nbb_checker.sv
module nbb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe,
  input logic       irq,
  input logic [7:0] mode_q,
  input logic [7:0] mask_q
);
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R6

  AST_WE_STALLS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !req_ready); // R7

  AST_OE_STALLS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> !req_ready); // R3

  AST_MODE_HELD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mode_q)); // R7

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q[7] && mask_q[0])); // R10
endmodule

bind nbb_top nbb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .irq        (irq),
  .mode_q     (mode_q),
  .mask_q     (mask_q)
);

// File: tb/nbb_top_tb_top.sv
`timescale 1ns/1ps
module nbb_top_tb_top;
  localparam int PULSE = 3;
  localparam int RECOV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_wp_n;
  logic        nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb = 1'b1;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  nbb_top #(.PULSE_CYC(PULSE), .RECOV_CYC(RECOV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wide(req_wide), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_wp_n(nand_wp_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb(nand_rb), .irq(irq)
  );

  // ---------------- device model and strobe monitors ----------------
  logic [7:0] wlog [0:31];
  logic [2:0] wctl [0:31];   // {cle, ale, ce_n} at rising write strobe
  int  wcnt = 0;
  int  oe_bad = 0;
  logic [7:0] rd_bytes [0:1];
  int  rd_idx = 0;
  int  we_low = 0, re_low = 0, pw_bad = 0, pw_seen = 0, overlap = 0;

  always @(posedge nand_we_n) if (rst_n) begin
    wlog[wcnt % 32] = nand_dq_o;
    wctl[wcnt % 32] = {nand_cle, nand_ale, nand_ce_n};
    if (!nand_dq_oe) oe_bad++;
    if (we_low != PULSE) pw_bad++;
    pw_seen++;
    we_low = 0;
    wcnt++;
  end

  always @(posedge nand_re_n) if (rst_n) begin
    if (re_low != PULSE) pw_bad++;
    pw_seen++;
    re_low = 0;
  end

  always @(negedge nand_re_n) begin
    nand_dq_i = rd_bytes[rd_idx % 2];
    rd_idx++;
  end

  always @(posedge clk) if (rst_n) begin
    if (!nand_we_n) we_low++;
    if (!nand_re_n) re_low++;
  end

  always @(negedge clk) if (rst_n && !nand_we_n && !nand_re_n) overlap++;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic wide, input logic [7:0] b0, input logic [7:0] b1);
    return wide ? {b1, b0} : {8'h00, b0};
  endfunction

  function automatic int exp_lat(input logic data, input logic wide);
    if (!data) return 1;
    return (wide ? 2 : 1) * (PULSE + RECOV) + 1;
  endfunction

  logic first_ready;

  task automatic xfer(input logic wr, input logic [2:0] a, input logic wide,
                      input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wide = wide; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first_ready = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] rd;
    int lat;
    int w0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", nand_ce_n, 1); chk("R1 we_n", nand_we_n, 1);
    chk("R1 re_n", nand_re_n, 1); chk("R1 cle", nand_cle, 0);
    chk("R1 ale", nand_ale, 0);   chk("R1 irq", irq, 0);
    chk("R1 ready", req_ready, 1); chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 oe", nand_dq_oe, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    xfer(0, 3'd4, 0, 0, rd, lat); chk("R1 mode", rd, 0);
    xfer(0, 3'd7, 0, 0, rd, lat); chk("R1 mask", rd, 0);
    xfer(0, 3'd6, 0, 0, rd, lat); chk("R1 flag", rd, 0);
    chk("R7 reg latency", lat, exp_lat(0, 0));

    // R2 mode pins
    xfer(1, 3'd4, 0, 16'h0095, rd, lat);
    chk("R2 cmd pins", {nand_ce_n, nand_cle, nand_ale}, 3'b010);
    xfer(0, 3'd4, 0, 0, rd, lat); chk("R2 readback", rd, 16'h0095);
    xfer(1, 3'd4, 0, 16'h0096, rd, lat);
    chk("R2 addr pins", {nand_ce_n, nand_cle, nand_ale}, 3'b001);
    xfer(1, 3'd4, 0, 16'h0094, rd, lat);
    chk("R2 data pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b0001);
    xfer(1, 3'd4, 0, 16'h0000, rd, lat);
    chk("R2 standby", {nand_ce_n, nand_wp_n}, 2'b10);

    // R4 narrow command write
    xfer(1, 3'd4, 0, 16'h0095, rd, lat);
    w0 = wcnt;
    xfer(1, 3'd0, 0, 16'hBEFF, rd, lat);
    chk("R7 stalled", first_ready, 0);
    chk("R7 narrow latency", lat, exp_lat(1, 0));
    chk("R4 count", wcnt - w0, 1);
    chk("R4 byte", wlog[w0 % 32], 8'hFF);
    chk("R4 cle phase", wctl[w0 % 32], 3'b100);

    // R3 wide data write
    xfer(1, 3'd4, 0, 16'h0094, rd, lat);
    w0 = wcnt;
    xfer(1, 3'd0, 1, 16'hA55A, rd, lat);
    chk("R7 wide latency", lat, exp_lat(1, 1));
    chk("R3 count", wcnt - w0, 2);
    chk("R3 low first", wlog[w0 % 32], 8'h5A);
    chk("R3 high second", wlog[(w0 + 1) % 32], 8'hA5);
    chk("R3 oe", oe_bad, 0);

    // R5 reads
    rd_bytes[0] = 8'h12; rd_bytes[1] = 8'h34; rd_idx = 0;
    xfer(0, 3'd0, 1, 0, rd, lat);
    chk("R5 wide read", rd, 16'h3412);
    rd_bytes[0] = 8'h9C; rd_bytes[1] = 8'hEE; rd_idx = 0;
    xfer(0, 3'd0, 0, 0, rd, lat);
    chk("R5 narrow read", rd, 16'h009C);
    chk("R7 read latency", lat, exp_lat(1, 0));

    // R8 status busy
    @(negedge clk); nand_rb = 1'b0; wait_cyc(4);
    xfer(0, 3'd5, 0, 0, rd, lat); chk("R8 busy", rd, 16'h0080);
    // R9 falling edge does not set flag
    xfer(0, 3'd6, 0, 0, rd, lat); chk("R9 fall no flag", rd, 0);
    @(negedge clk); nand_rb = 1'b1; wait_cyc(5);
    xfer(0, 3'd5, 0, 0, rd, lat); chk("R8 ready", rd, 0);
    xfer(0, 3'd6, 0, 0, rd, lat); chk("R9 rise flag", rd, 16'h0001);
    chk("R10 masked off", irq, 0);
    xfer(1, 3'd7, 0, 16'h0001, rd, lat); @(negedge clk);
    chk("R10 one mask bit", irq, 0);
    xfer(1, 3'd7, 0, 16'h0081, rd, lat); @(negedge clk);
    chk("R10 enabled", irq, 1);
    xfer(1, 3'd6, 0, 16'h000F, rd, lat); @(negedge clk);
    chk("R9 cleared irq", irq, 0);
    xfer(0, 3'd6, 0, 0, rd, lat); chk("R9 cleared flag", rd, 0);
    xfer(1, 3'd7, 0, 16'h0000, rd, lat);
    @(negedge clk); nand_rb = 1'b0; wait_cyc(4);
    @(negedge clk); nand_rb = 1'b1; wait_cyc(5);
    chk("R10 mask zero", irq, 0);
    xfer(0, 3'd6, 0, 0, rd, lat); chk("R10 flag pending", rd, 16'h0001);
    xfer(1, 3'd6, 0, 16'h000F, rd, lat);

    // R11 unmapped offsets
    xfer(1, 3'd1, 0, 16'h00FF, rd, lat);
    xfer(0, 3'd1, 0, 0, rd, lat); chk("R11 off1", rd, 0);
    xfer(0, 3'd3, 0, 0, rd, lat); chk("R11 off3", rd, 0);
    xfer(0, 3'd4, 0, 0, rd, lat); chk("R11 mode kept", rd, 16'h0094);

    // random data traffic
    void'($urandom(32'd4711));
    for (int it = 0; it < 24; it++) begin
      logic [31:0] r;
      logic wr, wide;
      r = $urandom();
      wide = r[0]; wr = r[1];
      if (wr) begin
        w0 = wcnt;
        xfer(1, 3'd0, wide, r[31:16], rd, lat);
        chk("R3 rand count", wcnt - w0, wide ? 2 : 1);
        chk("R4 rand byte0", wlog[w0 % 32], r[23:16]);
        if (wide) chk("R3 rand byte1", wlog[(w0 + 1) % 32], r[31:24]);
      end else begin
        rd_bytes[0] = r[15:8]; rd_bytes[1] = r[31:24]; rd_idx = 0;
        xfer(0, 3'd0, wide, 0, rd, lat);
        chk("R5 rand read", rd, exp_read(wide, r[15:8], r[31:24]));
      end
      chk("R7 rand latency", lat, exp_lat(1, wide));
    end

    // R6 strobe width and exclusivity
    chk("R6 pulse width", pw_bad, 0);
    chk("R6 pulses seen", pw_seen > 10, 1);
    chk("R6 no overlap", overlap, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule